// File: doc/BRIEF.md
# SPI Serial Flash Command Slave

This block sits behind the serial pins of a chip and answers a host as a small serial flash would. The host lowers an active-low chip select, clocks eight-bit instructions in on the data input, most significant bit first, and reads replies on a data output whose driver the block turns on only while it has data to return. The instruction set covers:

- continuous memory read with a three-byte address;
- a manufacturer/device identification pair;
- a three-byte standard identity;
- a status byte;
- setting and clearing a write-enable latch;
- a single-byte program;
- sector and block erase.

Byte storage is a small on-chip RAM. Erase work is handed to an outside engine through a request/done pair.

The pins are brought into the block's own clock domain through two-flop synchronizers, and the serial clock edges are found there. The serial clock must therefore be several times slower than the core clock. Both idle polarities of the serial clock (modes 0 and 3) are accepted. Every write-type instruction acts only on the rising edge of chip select, and only if it arrived whole while the write-enable latch was set.

Top module: `spi_flash_slave`

## Requirements
- R1: Input bits are taken on rising serial clock edges, MSB first, in both mode 0 (clock idles low) and mode 3 (clock idles high). Output bits change only after falling edges.
- R2: Opcode 03h followed by three address bytes streams RAM bytes starting at the address, taken modulo 2^MEM_AW. The address increments per byte and wraps, for as long as chip select stays low.
- R3: Opcode 06h sets the write-enable latch and opcode 04h clears it, on the chip-select rise after the complete opcode. The latch reads back as status bit 1.
- R4: Opcode 02h followed by three address bytes and one data byte writes that byte to RAM at chip-select rise, only if the write-enable latch is set. A write that happens clears the latch.
- R5: Opcode 20h (sector) or D8h (block) followed by three address bytes, with the latch set and the block not busy, gives at chip-select rise a one-cycle exec_req_o. The request carries exec_addr_o and exec_blk_o, which is 1 for block and 0 for sector. It sets busy (status bit 0) until exec_done_i, which then clears both busy and the latch.
- R6: Opcode 05h returns the status byte repeatedly until chip select rises. Bit 0 is busy, bit 1 is write enable, and bits 7..2 are zero.
- R7: Opcode 9Fh returns 8Ch, 20h, 13h and repeats that triple.
- R8: Opcodes 90h and ABh take three address bytes, then return the manufacturer byte 8Ch and the device byte DEV_ID (default 12h), alternating. Address bit 0 set to 1 puts the device byte first.
- R9: so_oe_o is low while chip select is high, during opcode and address bytes, and for every instruction that returns no data.
- R10: An unknown opcode gives no output and changes no state. Later bytes in the same select window are ignored.
- R11: A command cut short, by chip select rising mid-byte or before all its bytes, has no effect.
- R12: While busy, program and erase instructions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output-driver enable for so_o (pad tri-state control) |
| exec_req_o | output | 1 | One-cycle erase request |
| exec_blk_o | output | 1 | Erase size: 1 block, 0 sector |
| exec_addr_o | output | ADDR_W | Erase address |
| exec_done_i | input | 1 | Erase engine completion |

## Verification
The hardest situation to reach is an instruction cut short with the latch set. Chip select must rise after the opcode and address but one bit short of the data byte. The bench then has to show, through a later read and a status read, that memory is unchanged while the latch is still set.

The busy window is reached by issuing an erase and holding exec_done_i low. A program and a second erase are sent inside that window, and their absence is seen through the RAM contents and the request counter.

All 256 RAM locations are programmed with an arithmetic pattern, alternating the clock mode by address. They are then streamed back in both modes, including a wrap past the top address.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [3:0] {
    C_NONE, C_READ, C_IDPAIR, C_IDSTD, C_STAT, C_WEN, C_WDIS,
    C_PROG, C_ERS_S, C_ERS_B, C_BAD
  } cmd_e;

  function automatic cmd_e decode_op(input logic [7:0] op);
    case (op)
      8'h03:        return C_READ;
      8'h90, 8'hAB: return C_IDPAIR;
      8'h9F:        return C_IDSTD;
      8'h05:        return C_STAT;
      8'h06:        return C_WEN;
      8'h04:        return C_WDIS;
      8'h02:        return C_PROG;
      8'h20:        return C_ERS_S;
      8'hD8:        return C_ERS_B;
      default:      return C_BAD;
    endcase
  endfunction
endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/sfl_rx.sv
module sfl_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       rise_i,
  input  logic       si_i,
  output logic [2:0] bit_cnt_o,
  output logic [7:0] byte_o,
  output logic       byte_vld_o
);
  logic [6:0] sh_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_o <= '0;
      sh_q      <= '0;
    end else if (clr_i) begin
      bit_cnt_o <= '0;
    end else if (rise_i) begin
      bit_cnt_o <= bit_cnt_o + 3'd1;
      sh_q      <= {sh_q[5:0], si_i};
    end
  end
  assign byte_o     = {sh_q, si_i};
  assign byte_vld_o = rise_i && (bit_cnt_o == 3'd7);
endmodule

// File: rtl/sfl_ram.sv
module sfl_ram #(
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_flash_slave.sv
module spi_flash_slave
  import sfl_pkg::*;
#(
  parameter int          MEM_AW = 8,
  parameter int          ADDR_W = 24,
  parameter logic [7:0]  MFR_ID = 8'h8C,
  parameter logic [7:0]  TYPE_ID = 8'h20,
  parameter logic [7:0]  CAP_ID = 8'h13,
  parameter logic [7:0]  DEV_ID = 8'h12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              exec_req_o,
  output logic              exec_blk_o,
  output logic [ADDR_W-1:0] exec_addr_o,
  input  logic              exec_done_i
);
  localparam int ABYTES = ADDR_W / 8;
  localparam int IDX_W  = $clog2(ABYTES + 3);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(ABYTES + 1);
  localparam logic [IDX_W-1:0] IDX_MAX  = IDX_W'(ABYTES + 2);

  logic cs_s, sck_s, si_s, sck_q, cs_q;
  sfl_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i({cs_ni, sck_i, si_i}), .q_o({cs_s, sck_s, si_s}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  logic sck_rise, sck_fall, cs_rise;
  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign sck_fall = ~sck_s & sck_q & ~cs_s;
  assign cs_rise  = cs_s & ~cs_q;

  logic [2:0] bit_cnt;
  logic [7:0] rx_byte;
  logic       byte_vld;
  sfl_rx u_rx (
    .clk_i, .rst_ni, .clr_i(cs_s), .rise_i(sck_rise), .si_i(si_s),
    .bit_cnt_o(bit_cnt), .byte_o(rx_byte), .byte_vld_o(byte_vld));

  cmd_e              cmd_q, op_dec;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q, addr_full;
  logic [7:0]        data_q, tx_q, next_byte, rd_data;
  logic [MEM_AW-1:0] rd_addr_q;
  logic [1:0]        oidx_q;
  logic              sel_q, stream_q, oe_q, wel_q, busy_q;
  logic              hdr_done, load, ram_we, ers_go, whole;

  assign op_dec    = decode_op(rx_byte);
  assign addr_full = {addr_q[ADDR_W-9:0], rx_byte};
  assign hdr_done  = byte_vld &&
                     ((idx_q == '0 && (op_dec == C_IDSTD || op_dec == C_STAT)) ||
                      (idx_q == IDX_W'(ABYTES) && (cmd_q == C_READ || cmd_q == C_IDPAIR)));
  assign load      = sck_fall && stream_q && bit_cnt == 3'd0;

  // command framing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= C_NONE;
      idx_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (cs_s) begin
      cmd_q <= C_NONE;
      idx_q <= '0;
    end else if (byte_vld) begin
      if (idx_q == '0) cmd_q <= op_dec;
      if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
      if (idx_q != '0 && idx_q <= IDX_W'(ABYTES)) addr_q <= addr_full;
      if (idx_q == IDX_DATA) data_q <= rx_byte;
    end
  end

  always_comb begin
    case (cmd_q)
      C_READ:   next_byte = rd_data;
      C_IDPAIR: next_byte = (oidx_q[0] ^ sel_q) ? DEV_ID : MFR_ID;
      C_IDSTD:  next_byte = (oidx_q == 2'd0) ? MFR_ID : (oidx_q == 2'd1) ? TYPE_ID : CAP_ID;
      C_STAT:   next_byte = {6'b0, wel_q, busy_q};
      default:  next_byte = 8'h00;
    endcase
  end

  // output stream
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stream_q  <= 1'b0;
      oe_q      <= 1'b0;
      tx_q      <= '0;
      rd_addr_q <= '0;
      oidx_q    <= '0;
      sel_q     <= 1'b0;
    end else if (cs_s) begin
      stream_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (hdr_done) begin
        stream_q  <= 1'b1;
        rd_addr_q <= addr_full[MEM_AW-1:0];
        sel_q     <= addr_full[0];
        oidx_q    <= '0;
      end
      if (load) begin
        oe_q      <= 1'b1;
        tx_q      <= next_byte;
        rd_addr_q <= rd_addr_q + 1'b1;
        oidx_q    <= (cmd_q == C_IDSTD && oidx_q == 2'd2) ? 2'd0 : oidx_q + 2'd1;
      end else if (sck_fall && oe_q) begin
        tx_q <= {tx_q[6:0], 1'b0};
      end
    end
  end

  assign so_o    = tx_q[7];
  assign so_oe_o = oe_q;

  // commit at chip-select rise
  assign whole  = cs_rise && bit_cnt == 3'd0;
  assign ram_we = whole && cmd_q == C_PROG && idx_q == IDX_MAX && wel_q && !busy_q;
  assign ers_go = whole && (cmd_q == C_ERS_S || cmd_q == C_ERS_B) &&
                  idx_q >= IDX_DATA && wel_q && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q       <= 1'b0;
      busy_q      <= 1'b0;
      exec_req_o  <= 1'b0;
      exec_blk_o  <= 1'b0;
      exec_addr_o <= '0;
    end else begin
      exec_req_o <= ers_go;
      if (ers_go) begin
        busy_q      <= 1'b1;
        exec_blk_o  <= (cmd_q == C_ERS_B);
        exec_addr_o <= addr_q;
      end
      if (busy_q && exec_done_i) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
      end else if (ram_we) begin
        wel_q <= 1'b0;
      end else if (whole && idx_q != '0 && cmd_q == C_WEN) begin
        wel_q <= 1'b1;
      end else if (whole && idx_q != '0 && cmd_q == C_WDIS) begin
        wel_q <= 1'b0;
      end
    end
  end

  sfl_ram #(.AW(MEM_AW)) u_ram (
    .clk_i, .we_i(ram_we), .waddr_i(addr_q[MEM_AW-1:0]), .wdata_i(data_q),
    .raddr_i(rd_addr_q), .rdata_o(rd_data));

  // R1
  oe_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(sck_fall));
  // R9
  oe_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !oe_q);
  // R3
  wel_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(cs_rise));
  // R5
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_req_o |=> !exec_req_o);
  // R12
  req_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_req_o |-> !$past(busy_q));
  // R4
  wel_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wel_q) |-> $past(cs_rise) || $past(exec_done_i));
endmodule

// File: tb/sim_spi_flash_slave.sv
module sim_spi_flash_slave;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, exec_done = 1'b0;
  logic so, so_oe, exec_req, exec_blk;
  logic [23:0] exec_addr;
  int n_chk = 0, n_fail = 0, req_cnt = 0;
  logic [23:0] req_addr;
  logic req_blk;
  bit mode3 = 1'b0;

  always #10 clk = ~clk;

  spi_flash_slave u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .exec_req_o(exec_req), .exec_blk_o(exec_blk),
    .exec_addr_o(exec_addr), .exec_done_i(exec_done));

  always @(posedge clk) if (exec_req) begin
    req_cnt  <= req_cnt + 1;
    req_addr <= exec_addr;
    req_blk  <= exec_blk;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a & 255) * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    sck = mode3;
    wt(4);
    cs_n = 1'b0;
    wt(4);
  endtask

  task automatic cs_hi();
    if (!mode3) sck = 1'b0;
    wt(4);
    cs_n = 1'b1;
    wt(8);
  endtask

  task automatic xbits(input logic [7:0] d, input int nb, output logic [7:0] r, output bit oe_all, output bit oe_any);
    r = '0; oe_all = 1; oe_any = 0;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0;
      si  = d[i];
      wt(4);
      r = {r[6:0], so};
      oe_all &= so_oe;
      oe_any |= so_oe;
      sck = 1'b1;
      wt(4);
    end
  endtask

  task automatic xb(input logic [7:0] d, output logic [7:0] r, output bit oe_all, output bit oe_any);
    xbits(d, 8, r, oe_all, oe_any);
  endtask

  task automatic hdr(input logic [7:0] op, input logic [23:0] a, input bit with_addr, output bit oe_seen);
    logic [7:0] r; bit al, an;
    xb(op, r, al, an); oe_seen = an;
    if (with_addr) for (int k = 2; k >= 0; k--) begin
      xb(a[k*8 +: 8], r, al, an); oe_seen |= an;
    end
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r; bit al, an;
    cs_lo(); xb(op, r, al, an); cs_hi();
  endtask

  task automatic status(output logic [7:0] s);
    bit al, an; logic [7:0] r;
    cs_lo(); xb(8'h05, r, al, an); xb(8'h00, s, al, an); cs_hi();
  endtask

  task automatic prog(input logic [23:0] a, input logic [7:0] d, input int nbits);
    bit oe; logic [7:0] r; bit al, an;
    cs_lo(); hdr(8'h02, a, 1, oe); xbits(d, nbits, r, al, an); cs_hi();
  endtask

  task automatic erase(input logic [7:0] op, input logic [23:0] a);
    bit oe;
    cs_lo(); hdr(op, a, 1, oe); cs_hi();
  endtask

  task automatic rd_chk(input logic [23:0] a, input int n, input string req);
    bit oe, al, an; logic [7:0] r;
    cs_lo(); hdr(8'h03, a, 1, oe);
    chk(!oe, "R9 header oe", 32'(oe), 0);
    for (int i = 0; i < n; i++) begin
      xb(8'h00, r, al, an);
      chk(r == pat(int'(a[7:0]) + i) && al, req, {23'b0, al, r}, {24'h1, pat(int'(a[7:0]) + i)});
    end
    cs_hi();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, r; bit oe, al, an;
    logic [7:0] exp_std [3];
    exp_std[0] = 8'h8C; exp_std[1] = 8'h20; exp_std[2] = 8'h13;
    wt(5); rst_ni = 1'b1; wt(5);
    chk(!so_oe && !exec_req, "R9 reset", {so_oe, exec_req}, 0);
    status(s); chk(s == 8'h00, "R6 reset status", s, 8'h00);

    // R3 latch set/clear, R11 partial opcode
    op1(8'h06); status(s); chk(s == 8'h02, "R3 wren", s, 8'h02);
    op1(8'h04); status(s); chk(s == 8'h00, "R3 wrdi", s, 8'h00);
    cs_lo(); xbits(8'h06, 5, r, al, an); cs_hi();
    status(s); chk(s == 8'h00, "R11 partial wren", s, 8'h00);

    // R4 R1 program every location, mode alternating
    for (int a = 0; a < 256; a++) begin
      mode3 = a[0];
      op1(8'h06);
      prog(24'h3A0000 | 24'(a), pat(a), 8);
    end
    mode3 = 0;
    status(s); chk(s == 8'h00, "R4 wel cleared after program", s, 8'h00);
    prog(24'h5, ~pat(5), 8);
    rd_chk(24'h5, 1, "R4 program without wel ignored");
    op1(8'h06); prog(24'h6, ~pat(6), 7);
    rd_chk(24'h6, 1, "R11 truncated program");
    status(s); chk(s == 8'h02, "R11 wel kept after abort", s, 8'h02);
    op1(8'h04);

    // R2 streaming read, wrap, both modes
    rd_chk(24'h1234F0, 40, "R2 read wrap mode0");
    mode3 = 1; rd_chk(24'h0, 256, "R2 read full mode3"); mode3 = 0;

    // R7
    for (int m = 0; m < 2; m++) begin
      mode3 = m[0];
      cs_lo(); hdr(8'h9F, 0, 0, oe);
      for (int i = 0; i < 6; i++) begin
        xb(0, r, al, an);
        chk(r == exp_std[i % 3] && al, "R7 std id", r, exp_std[i % 3]);
      end
      cs_hi();
    end
    mode3 = 0;

    // R8
    cs_lo(); hdr(8'h90, 24'h0, 1, oe);
    chk(!oe, "R9 id header oe", 32'(oe), 0);
    for (int i = 0; i < 4; i++) begin
      xb(0, r, al, an);
      chk(r == (i[0] ? 8'h12 : 8'h8C), "R8 id order a0=0", r, i[0] ? 8'h12 : 8'h8C);
    end
    cs_hi();
    cs_lo(); hdr(8'hAB, 24'h1, 1, oe);
    for (int i = 0; i < 4; i++) begin
      xb(0, r, al, an);
      chk(r == (i[0] ? 8'h8C : 8'h12), "R8 id order a0=1", r, i[0] ? 8'h8C : 8'h12);
    end
    cs_hi();

    // R10 unknown opcode
    cs_lo(); xb(8'hFF, r, al, an); xb(8'h06, r, al, oe); xb(8'h00, r, al, an); cs_hi();
    chk(!oe && !an, "R10 unknown opcode output", {oe, an}, 0);
    status(s); chk(s == 8'h00, "R10 unknown opcode state", s, 8'h00);

    // R9 no output for write commands
    op1(8'h06);
    cs_lo(); hdr(8'h02, 24'h9, 1, oe); xb(pat(9), r, al, an); cs_hi();
    chk(!oe && !an, "R9 program no output", {oe, an}, 0);

    // R5 erase without wel
    erase(8'h20, 24'h000100);
    chk(req_cnt == 0, "R5 erase without wel", req_cnt, 0);
    op1(8'h06); erase(8'h20, 24'h012345);
    chk(req_cnt == 1 && req_addr == 24'h012345 && !req_blk, "R5 sector request",
        {req_cnt[6:0], req_blk, req_addr}, {7'd1, 1'b0, 24'h012345});
    // R6 repeated status while busy
    cs_lo(); xb(8'h05, r, al, an);
    for (int i = 0; i < 3; i++) begin
      xb(0, s, al, an); chk(s == 8'h03 && al, "R6 status repeat busy", s, 8'h03);
    end
    cs_hi();
    // R12 ignored while busy
    prog(24'h7, ~pat(7), 8);
    erase(8'hD8, 24'h0A0000);
    chk(req_cnt == 1, "R12 erase while busy", req_cnt, 1);
    rd_chk(24'h7, 1, "R12 program while busy");
    wt(2); exec_done = 1'b1; wt(1); exec_done = 1'b0; wt(2);
    status(s); chk(s == 8'h00, "R5 done clears busy and wel", s, 8'h00);
    mode3 = 1;
    op1(8'h06); erase(8'hD8, 24'h0A0000);
    chk(req_cnt == 2 && req_addr == 24'h0A0000 && req_blk, "R5 block request",
        {req_cnt[6:0], req_blk, req_addr}, {7'd2, 1'b1, 24'h0A0000});
    wt(2); exec_done = 1'b1; wt(1); exec_done = 1'b0; wt(2);
    // R11 erase cut before last address byte
    op1(8'h06);
    cs_lo(); hdr(8'h20, 0, 0, oe); xb(8'h01, r, al, an); xb(8'h02, r, al, an); cs_hi();
    chk(req_cnt == 2, "R11 short erase", req_cnt, 2);
    status(s); chk(s == 8'h02, "R11 short erase state", s, 8'h02);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule